// File: doc/BRIEF.md
# Output Stage Power-On Switch Sequencer

This block drives the six analog switches that shape a converter channel's output stage. Two of them choose what feeds the output amplifier: the converter itself or the ground-sense node. Two set how the amplifier is wired: as a unity buffer or as a gain-of-two stage. The last two either clamp the output resistively to ground-sense or leave it free. The block takes two supply-good flags from rail comparators and an active-low clear. It produces a six-bit enable vector in which bit i set means switch G(i+1) is closed.

After reset the stage stays in a safe power-up arrangement: buffer wiring plus the output clamp. The amplifier input follows the clear level. Only when both supply flags have been true for a programmable number of consecutive clock cycles does the block release the clamp and select the gain stage. From then on, clear alone chooses whether the output follows the converter or ground-sense. When the enable vector must both open and close switches, it first opens the released ones in one cycle and closes the new ones in the next.

Top module: `pss_top`

## Requirements
- R1: While reset is asserted, the enable vector is 6'b010100 (only G3 and G5 closed).
- R2: Before the supplies qualify and with clear low, the vector settles to 6'b010110 (G2, G3 and G5 closed).
- R3: Before the supplies qualify and with clear high, the vector settles to 6'b010101 (G1, G3 and G5 closed).
- R4: The supplies qualify only after both flags have been sampled true on `qual_len` consecutive rising edges, with a value of 0 treated as 1. A single flag, or a run that is too short, leaves the power-up arrangement in place.
- R5: After qualification and with clear low, the vector settles to 6'b101010 (G2, G4 and G6 closed).
- R6: After qualification and with clear high, the vector settles to 6'b101001 (G1, G4 and G6 closed).
- R7: No clock edge both opens and closes switches. A change that needs both first moves to the bitwise AND of the old and new vectors for one cycle.
- R8: If either flag drops after qualification, qualification is lost at the next edge. The vector then returns, through the R7 sequence, to the power-up arrangement for the present clear level.
- R9: Within each of the pairs G1/G2, G3/G4 and G5/G6, at most one switch is closed at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pos_ok | input | 1 | Positive rail above its threshold |
| neg_ok | input | 1 | Negative rail below its threshold |
| clr_n | input | 1 | Active-low clear: output follows ground-sense while low |
| qual_len | input | CNT_W | Consecutive cycles both flags must hold |
| sw_en | output | 6 | Switch enables, bit i closes G(i+1) |

## Verification
A clear edge and the completion of supply qualification can change the target in the same cycle. Either one can also land while a break phase is still in progress. The random phase flips clear and both flags together on the same negative edge, so the two causes combine. It then judges the settled vector against a table indexed by both conditions. A per-cycle monitor confirms that the combined change never opens and closes switches on one edge and never closes both members of a pair.

// File: rtl/pss_pkg.sv
package pss_pkg;
  localparam int NSW = 6;
  typedef logic [NSW-1:0] sw_vec_t;

  localparam sw_vec_t SW_G1 = 6'b000001;
  localparam sw_vec_t SW_G2 = 6'b000010;
  localparam sw_vec_t SW_G3 = 6'b000100;
  localparam sw_vec_t SW_G4 = 6'b001000;
  localparam sw_vec_t SW_G5 = 6'b010000;
  localparam sw_vec_t SW_G6 = 6'b100000;

  // Safe state before the clear level is known: buffer plus clamp.
  localparam sw_vec_t SW_RESET = SW_G3 | SW_G5;

  // Target switch set from rail qualification and clear level.
  function automatic sw_vec_t cfg_for(input logic rails_up, input logic clr_n);
    sw_vec_t v;
    v = rails_up ? (SW_G4 | SW_G6) : (SW_G3 | SW_G5);
    v = v | (clr_n ? SW_G1 : SW_G2);
    return v;
  endfunction
endpackage

// File: rtl/pss_supply_qual.sv
module pss_supply_qual #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pos_ok,
  input  logic             neg_ok,
  input  logic [CNT_W-1:0] qual_len,
  output logic             rails_ok,
  output logic             rails_up
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [EXT_W-1:0] cnt_nxt;
  logic             reached;

  assign rails_ok = pos_ok & neg_ok;
  assign cnt_nxt  = {1'b0, cnt_q} + EXT_W'(1);
  assign reached  = cnt_nxt >= {1'b0, qual_len};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      rails_up <= 1'b0;
    end else if (!rails_ok) begin
      cnt_q    <= '0;
      rails_up <= 1'b0;
    end else if (!rails_up) begin
      if (reached) rails_up <= 1'b1;
      else         cnt_q    <= cnt_nxt[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/pss_sw_seq.sv
module pss_sw_seq
  import pss_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  sw_vec_t tgt,
  output sw_vec_t sw,
  output logic    brk_phase,
  output logic    mk_phase
);
  sw_vec_t rel_m, cls_m;

  assign rel_m     = sw & ~tgt;
  assign cls_m     = tgt & ~sw;
  assign brk_phase = |rel_m;
  assign mk_phase  = !brk_phase && (|cls_m);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sw <= SW_RESET;
    else if (brk_phase) sw <= sw & tgt;
    else if (mk_phase)  sw <= tgt;
  end
endmodule

// File: rtl/pss_top.sv
module pss_top
  import pss_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pos_ok,
  input  logic             neg_ok,
  input  logic             clr_n,
  input  logic [CNT_W-1:0] qual_len,
  output logic [5:0]       sw_en
);
  logic    rails_ok, rails_up, brk_phase, mk_phase;
  sw_vec_t tgt, sw;

  pss_supply_qual #(.CNT_W(CNT_W)) u_qual (
    .clk(clk), .rst_n(rst_n), .pos_ok(pos_ok), .neg_ok(neg_ok),
    .qual_len(qual_len), .rails_ok(rails_ok), .rails_up(rails_up)
  );

  assign tgt = cfg_for(rails_up, clr_n);

  pss_sw_seq u_seq (
    .clk(clk), .rst_n(rst_n), .tgt(tgt), .sw(sw),
    .brk_phase(brk_phase), .mk_phase(mk_phase)
  );

  assign sw_en = sw;
endmodule

// File: rtl/pss_chk.sv
module pss_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rails_ok,
  input logic       rails_up,
  input logic       clr_n,
  input logic [5:0] sw,
  input logic [5:0] tgt
);
  p_bbm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !((|(sw & ~$past(sw))) && (|($past(sw) & ~sw))));

  p_pairs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw[0] && sw[1]) && !(sw[2] && sw[3]) && !(sw[4] && sw[5]));

  p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rails_up && !rails_ok) |=> !rails_up);

  p_gain_needs_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw[3]) |-> $past(rails_up));

  p_clamp_needs_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw[4]) |-> !$past(rails_up));

  p_dac_needs_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw[0]) |-> $past(clr_n));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sw == tgt) |=> (sw == $past(sw)));
endmodule

bind pss_top pss_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rails_ok(rails_ok), .rails_up(rails_up),
  .clr_n(clr_n), .sw(sw), .tgt(tgt)
);

// File: tb/sim_pss_top.sv
module sim_pss_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pos_ok = 1'b0, neg_ok = 1'b0, clr_n = 1'b0;
  logic [7:0] qual_len = 8'd5;
  logic [5:0] sw_en;
  logic [5:0] prev_sw = 6'b010100;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  pss_top #(.CNT_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .pos_ok(pos_ok), .neg_ok(neg_ok),
    .clr_n(clr_n), .qual_len(qual_len), .sw_en(sw_en)
  );

  function automatic logic [5:0] exp_cfg(input logic up, input logic clr);
    case ({up, clr})
      2'b00:   return 6'b010110;
      2'b01:   return 6'b010101;
      2'b10:   return 6'b101010;
      default: return 6'b101001;
    endcase
  endfunction

  task automatic chk(input string req, input logic [5:0] got, input logic [5:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: sw_en=%b expected %b", req, got, exp);
    end
  endtask

  // Advance n cycles; sample at negedge and watch every change.
  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rst_n && sw_en !== prev_sw) begin
        checks++;
        if ((|(sw_en & ~prev_sw)) && (|(prev_sw & ~sw_en))) begin
          fails++;
          $display("FAIL R7: %b -> %b opens and closes together", prev_sw, sw_en);
        end
        checks++;
        if ((sw_en[0] & sw_en[1]) | (sw_en[2] & sw_en[3]) | (sw_en[4] & sw_en[5])) begin
          fails++;
          $display("FAIL R9: sw_en=%b expected no pair closed", sw_en);
        end
      end
      prev_sw = sw_en;
    end
  endtask

  initial begin
    #250000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    tick(3);
    chk("R1", sw_en, 6'b010100);
    rst_n = 1'b1;
    tick(2);
    chk("R2", sw_en, 6'b010110);
    clr_n = 1'b1;
    tick(1); chk("R7", sw_en, 6'b010100);
    tick(1); chk("R3", sw_en, 6'b010101);
    pos_ok = 1'b1;
    tick(10); chk("R4 single flag", sw_en, 6'b010101);
    neg_ok = 1'b1;
    tick(4);
    neg_ok = 1'b0;
    tick(1); chk("R4 short run", sw_en, 6'b010101);
    neg_ok = 1'b1;
    tick(5); chk("R4 not yet", sw_en, 6'b010101);
    tick(1); chk("R7", sw_en, 6'b000001);
    tick(1); chk("R6", sw_en, 6'b101001);
    clr_n = 1'b0;
    tick(1); chk("R7", sw_en, 6'b101000);
    tick(1); chk("R5", sw_en, 6'b101010);
    pos_ok = 1'b0;
    tick(1); chk("R8 hold", sw_en, 6'b101010);
    tick(1); chk("R8 break", sw_en, 6'b000010);
    tick(1); chk("R8", sw_en, 6'b010110);
    qual_len = 8'd0;
    pos_ok = 1'b1;
    tick(3); chk("R4 zero length", sw_en, 6'b101010);

    // Random phase: clear and both flags change together.
    qual_len = 8'd3;
    for (int k = 0; k < 200; k++) begin
      logic [2:0] r;
      r = 3'($urandom());
      pos_ok = r[0]; neg_ok = r[1]; clr_n = r[2];
      tick(12);
      chk("R2/R3/R5/R6 random", sw_en, exp_cfg(r[0] & r[1], r[2]));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule